// File: doc/BRIEF.md
# Flash Program Interlock Controller

This block guards the programming sequence of an embedded flash array. It sits on a simple bus that carries an address, write data, a write strobe, a read strobe, and a select between register space and array space. A four-state machine follows the sequence from idle, through arming and filling the page buffer, to the high-voltage pulse. In each state the machine decides whether array writes are captured into a 16-word page buffer and whether the high-voltage enable bit may change.

While the buffer is being filled, each array read is a margin read. The verify result, supplied as a per-bit pass mask, clears the buffered bits that need no more programming. A word's valid flag drops once none of its bits are pending. The analog generator, the pulse timer and the cell array are outside the block. They are stood in for by the `array_rdata`, `margin_pass` and `pulse_done` inputs.

The bus is always ready. Every strobe is taken in the cycle it is asserted, and nothing can push back. Read data is registered and appears one cycle after the read strobe. It holds its value until the next accepted read.

Top module: `flash_pgm_interlock`

## Requirements
- R1: After reset the state code is 0 (idle), `hv_en` is 0, every buffer valid flag is 0, and the control registers and read data are zero.
- R2: From idle, a register write at offset 0 with bit 1 (program/erase select) = 0 and bit 0 (setup enable) = 1 moves the state to code 1 (armed). The same write with bit 1 = 1 leaves the state at 0. Array writes in idle latch nothing.
- R3: In the armed state, an array write moves the state to code 2 (filling). It stores the write data in buffer word `addr[5:2]`, sets that word's valid flag, and latches the full address on `prog_addr_o`. A register write in the armed state stores nothing in the buffer and leaves the state at 1.
- R4: A write to register offset 1 outside the filling and high-voltage states updates the pulse-width field (bits 11:4) but never changes the high-voltage enable bit (bit 0).
- R5: In the filling state, every array write replaces buffer word `addr[5:2]` and sets its valid flag. It loads `prog_blk_o` from the top 3 address bits and leaves `prog_addr_o` unchanged.
- R6: In the filling state, a write to offset 1 with bit 0 = 1 moves the state to code 3 (high voltage) and raises `hv_en`. `hv_en` is 1 exactly when the state code is 3.
- R7: From the armed or filling state, a write to offset 0 with bit 0 = 0 returns the state to 0 and clears every buffer word and valid flag.
- R8: In the filling state, an array read clears the bits of buffer word `addr[5:2]` that are set in `margin_pass`. It returns the remaining pending bits on `bus_rdata` and clears the valid flag when none remain. It also asserts `margin_rd`. In the other states, array reads return `array_rdata`.
- R9: In the high-voltage state, array writes and writes to offset 0 are ignored. A write to offset 1 with bit 0 = 0, or `pulse_done`, returns the state to 2 and clears `hv_en`. `pulse_done` wins over a same-cycle write of bit 0 = 1, while that write's pulse-width field still takes effect.
- R10: When `bus_wr` and `bus_rd` are asserted together, the write is performed and the read is dropped. `bus_rdata` holds its value and the buffer is not margin-cleared.
- R11: Register reads return the offset 0 value (bit 0 setup, bit 1 select, bits 15:8 block protect), the offset 1 value (bit 0 enable, bits 11:4 pulse width), and at offset 2 the state in bits 1:0 and the valid flags in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| bus_sel_reg | input | 1 | 1 selects register space, 0 selects array space |
| bus_addr | input | 18 | Byte address; bits 3:2 give the register offset, bits 5:2 the buffer word |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| array_rdata | input | 32 | Normal array read data from the cell array |
| margin_pass | input | 32 | Margin-verify result for the word being read, 1 = bit done |
| pulse_done | input | 1 | End of the high-voltage pulse from the pulse timer |
| hv_en | output | 1 | High-voltage enable to the generator |
| margin_rd | output | 1 | Current array read is a margin read |
| state_o | output | 2 | State code: 0 idle, 1 armed, 2 filling, 3 high voltage |
| prog_addr_o | output | 18 | Address latched by the first interlock write |
| prog_blk_o | output | 3 | Block address of the latest buffered write |
| buf_valid_o | output | 16 | Per-word valid flags of the page buffer |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the pulse-end handshake and a software write to the enable bit. The bench raises `pulse_done` in the same cycle as a write of enable = 1 with a new pulse width. It then expects the filling state, `hv_en` low, and the new width on readback. The second pair is a write and a margin read driven together: a buffer write is performed while the margin read is issued. The bench then checks that the new word is latched, that `bus_rdata` kept its old value, and that the read word's valid flag survived a pass mask that would have cleared it.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_FILL = 2'd2,
    ST_HV   = 2'd3
  } pi_state_e;

  localparam int CTL1_SES   = 0;
  localparam int CTL1_PE    = 1;
  localparam int CTL1_BP_LO = 8;
  localparam int CTL2_EHV   = 0;
  localparam int CTL2_PW_LO = 4;
  localparam int FIELD_W    = 8;
  localparam int STAT_VLD_LO = 16;

  localparam logic [1:0] OFF_CTL1 = 2'd0;
  localparam logic [1:0] OFF_CTL2 = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;
endpackage

// File: rtl/pi_fsm.sv
module pi_fsm
  import pi_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctl1,
  input  logic      wr_ctl2,
  input  logic      wr_arr,
  input  logic      rd_arr,
  input  logic      wd_ses,
  input  logic      wd_pe,
  input  logic      wd_ehv,
  input  logic      pulse_done,
  output pi_state_e state,
  output logic      latch_en,
  output logic      first_wr,
  output logic      flush,
  output logic      margin_en
);
  pi_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (wr_ctl1 && wd_ses && !wd_pe) nxt = ST_ARM;
      ST_ARM: begin
        if (wr_ctl1 && !wd_ses) nxt = ST_IDLE;
        else if (wr_arr)        nxt = ST_FILL;
      end
      ST_FILL: begin
        if (wr_ctl1 && !wd_ses)     nxt = ST_IDLE;
        else if (wr_ctl2 && wd_ehv) nxt = ST_HV;
      end
      ST_HV: if (pulse_done || (wr_ctl2 && !wd_ehv)) nxt = ST_FILL;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;

  assign latch_en  = wr_arr && (state == ST_ARM || state == ST_FILL);
  assign first_wr  = wr_arr && (state == ST_ARM);
  assign flush     = wr_ctl1 && !wd_ses && (state == ST_ARM || state == ST_FILL);
  assign margin_en = rd_arr && (state == ST_FILL);
endmodule

// File: rtl/pi_ctl_regs.sv
module pi_ctl_regs
  import pi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pi_state_e          state,
  input  logic               wr_ctl1,
  input  logic               wr_ctl2,
  input  logic               wd_ses,
  input  logic               wd_pe,
  input  logic               wd_ehv,
  input  logic [FIELD_W-1:0] wd_bp,
  input  logic [FIELD_W-1:0] wd_pw,
  input  logic               pulse_done,
  output logic               ses,
  output logic               pe,
  output logic [FIELD_W-1:0] bprot,
  output logic               ehv,
  output logic [FIELD_W-1:0] pw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ses   <= 1'b0;
      pe    <= 1'b0;
      bprot <= '0;
      ehv   <= 1'b0;
      pw    <= '0;
    end else begin
      if (wr_ctl1 && state != ST_HV) begin
        ses   <= wd_ses;
        pe    <= wd_pe;
        bprot <= wd_bp;
      end
      if (wr_ctl2) pw <= wd_pw;
      if (state == ST_HV && pulse_done)      ehv <= 1'b0;
      else if (wr_ctl2 && (state == ST_FILL || state == ST_HV))
                                              ehv <= wd_ehv;
    end
  end
endmodule

// File: rtl/pi_page_buf.sv
module pi_page_buf #(
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 18,
  parameter int BLK_W  = 3,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              first_wr,
  input  logic              flush,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     pass,
  output logic [DW-1:0]     word_o,
  output logic [WORDS-1:0]  valid_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [WORDS-1:0][DW-1:0] mem;
  logic [DW-1:0]            remain;

  assign word_o = mem[idx];
  assign remain = mem[idx] & ~pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem     <= '0;
      valid_o <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (flush) begin
          mem[i]     <= '0;
          valid_o[i] <= 1'b0;
        end else if (wr_en && idx == IDX_W'(i)) begin
          mem[i]     <= wdata;
          valid_o[i] <= 1'b1;
        end else if (clr_en && idx == IDX_W'(i)) begin
          mem[i]     <= remain;
          valid_o[i] <= |remain;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_o <= '0;
      blk_o <= '0;
    end else begin
      if (first_wr) tgt_o <= addr;
      if (wr_en)    blk_o <= addr[ADDR_W-1 -: BLK_W];
    end
  end
endmodule

// File: rtl/flash_pgm_interlock.sv
module flash_pgm_interlock
  import pi_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 18,
  parameter int BLK_W  = 3,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_reg,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     array_rdata,
  input  logic [DW-1:0]     margin_pass,
  input  logic              pulse_done,
  output logic              hv_en,
  output logic              margin_rd,
  output logic [1:0]        state_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [BLK_W-1:0]  prog_blk_o,
  output logic [WORDS-1:0]  buf_valid_o
);
  pi_state_e          state;
  logic [1:0]         off;
  logic [IDX_W-1:0]   idx;
  logic               wr_reg, wr_arr, rd_take, rd_arr;
  logic               wr_ctl1, wr_ctl2;
  logic               latch_en, first_wr, flush, margin_en;
  logic               ses, pe, ehv;
  logic [FIELD_W-1:0] bprot, pw;
  logic [DW-1:0]      buf_word, rd_mux;

  assign off     = bus_addr[3:2];
  assign idx     = bus_addr[IDX_W+1:2];
  assign wr_reg  = bus_wr && bus_sel_reg;
  assign wr_arr  = bus_wr && !bus_sel_reg;
  assign rd_take = bus_rd && !bus_wr;
  assign rd_arr  = rd_take && !bus_sel_reg;
  assign wr_ctl1 = wr_reg && off == OFF_CTL1;
  assign wr_ctl2 = wr_reg && off == OFF_CTL2;

  pi_fsm u_fsm (
    .clk, .rst_n, .wr_ctl1, .wr_ctl2, .wr_arr, .rd_arr,
    .wd_ses(bus_wdata[CTL1_SES]), .wd_pe(bus_wdata[CTL1_PE]),
    .wd_ehv(bus_wdata[CTL2_EHV]), .pulse_done,
    .state, .latch_en, .first_wr, .flush, .margin_en
  );

  pi_ctl_regs u_regs (
    .clk, .rst_n, .state, .wr_ctl1, .wr_ctl2,
    .wd_ses(bus_wdata[CTL1_SES]), .wd_pe(bus_wdata[CTL1_PE]),
    .wd_ehv(bus_wdata[CTL2_EHV]),
    .wd_bp(bus_wdata[CTL1_BP_LO +: FIELD_W]),
    .wd_pw(bus_wdata[CTL2_PW_LO +: FIELD_W]),
    .pulse_done, .ses, .pe, .bprot, .ehv, .pw
  );

  pi_page_buf #(.WORDS(WORDS), .DW(DW), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_buf (
    .clk, .rst_n, .wr_en(latch_en), .first_wr, .flush, .clr_en(margin_en),
    .idx, .addr(bus_addr), .wdata(bus_wdata), .pass(margin_pass),
    .word_o(buf_word), .valid_o(buf_valid_o), .tgt_o(prog_addr_o), .blk_o(prog_blk_o)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_sel_reg) begin
      unique case (off)
        OFF_CTL1: begin
          rd_mux[CTL1_SES] = ses;
          rd_mux[CTL1_PE]  = pe;
          rd_mux[CTL1_BP_LO +: FIELD_W] = bprot;
        end
        OFF_CTL2: begin
          rd_mux[CTL2_EHV] = ehv;
          rd_mux[CTL2_PW_LO +: FIELD_W] = pw;
        end
        OFF_STAT: begin
          rd_mux[1:0] = state;
          rd_mux[STAT_VLD_LO +: WORDS] = buf_valid_o;
        end
        default: rd_mux = '0;
      endcase
    end else if (state == ST_FILL) begin
      rd_mux = buf_word & ~margin_pass;
    end else begin
      rd_mux = array_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bus_rdata <= '0;
    else if (rd_take) bus_rdata <= rd_mux;

  assign hv_en     = ehv;
  assign margin_rd = margin_en;
  assign state_o   = state;
endmodule

// File: rtl/pi_checker.sv
module pi_checker #(
  parameter int WORDS  = 16,
  parameter int ADDR_W = 18,
  parameter int DW     = 32,
  parameter int BLK_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel_reg,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              pulse_done,
  input logic [1:0]        state_o,
  input logic              hv_en,
  input logic              margin_rd,
  input logic [WORDS-1:0]  buf_valid_o,
  input logic [BLK_W-1:0]  prog_blk_o
);
  logic wr_c1, wr_c2, wr_a;
  assign wr_c1 = bus_wr && bus_sel_reg && bus_addr[3:2] == 2'd0;
  assign wr_c2 = bus_wr && bus_sel_reg && bus_addr[3:2] == 2'd1;
  assign wr_a  = bus_wr && !bus_sel_reg;

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && wr_c1 && bus_wdata[0] && !bus_wdata[1]) |=> state_o == 2'd1);

  p_first_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && wr_a) |=> (state_o == 2'd2 && buf_valid_o[$past(bus_addr[5:2])]));

  p_hv_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en == (state_o == 2'd3));

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 2'd1 || state_o == 2'd2) && wr_c1 && !bus_wdata[0])
      |=> (state_o == 2'd0 && buf_valid_o == '0));

  p_margin_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    margin_rd |-> state_o == 2'd2);

  p_hv_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && wr_a) |=> ($stable(buf_valid_o) && $stable(prog_blk_o)));

  p_pulse_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && pulse_done) |=> (state_o == 2'd2 && !hv_en));

  p_ehv_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd2 && state_o != 2'd3 && wr_c2) |=> !hv_en);

  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |-> !margin_rd);
endmodule

bind flash_pgm_interlock pi_checker #(
  .WORDS(WORDS), .ADDR_W(ADDR_W), .DW(DW), .BLK_W(BLK_W)
) u_pi_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel_reg(bus_sel_reg), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .pulse_done(pulse_done),
  .state_o(state_o), .hv_en(hv_en), .margin_rd(margin_rd),
  .buf_valid_o(buf_valid_o), .prog_blk_o(prog_blk_o)
);

// File: tb/test_flash_pgm_interlock.sv
`timescale 1ns/1ps
module test_flash_pgm_interlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel_reg = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] array_rdata = '0;
  logic [31:0] margin_pass = '0;
  logic        pulse_done = 1'b0;
  logic        hv_en, margin_rd;
  logic [1:0]  state_o;
  logic [17:0] prog_addr_o;
  logic [2:0]  prog_blk_o;
  logic [15:0] buf_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_pgm_interlock i_flash_pgm_interlock (
    .clk, .rst_n, .bus_sel_reg, .bus_addr, .bus_wdata, .bus_wr, .bus_rd,
    .bus_rdata, .array_rdata, .margin_pass, .pulse_done, .hv_en, .margin_rd,
    .state_o, .prog_addr_o, .prog_blk_o, .buf_valid_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic sel, input logic [17:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel_reg = sel; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [17:0] a, input logic [31:0] pass,
                    output logic [31:0] d, output logic mrd);
    @(negedge clk);
    bus_sel_reg = sel; bus_addr = a; margin_pass = pass; bus_rd = 1'b1;
    #1 mrd = margin_rd;
    @(negedge clk);
    bus_rd = 1'b0; margin_pass = '0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic m;
    check("R1 state", 32'(state_o), 0);
    check("R1 hv_en", 32'(hv_en), 0);
    check("R1 valid", 32'(buf_valid_o), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(1'b1, 18'h4, 0, d, m);
    check("R1 ctl2 zero", d, 0);
    rd(1'b1, 18'h8, 0, d, m);
    check("R11 status idle", d, 0);
  endtask

  task automatic t_arm();
    logic [31:0] d; logic m;
    wr(1'b0, 18'h0_0010, 32'hFFFF_FFFF);
    check("R2 idle array write ignored", 32'(buf_valid_o), 0);
    wr(1'b1, 18'h0, 32'h0000_0003);
    check("R2 erase select stays idle", 32'(state_o), 0);
    wr(1'b1, 18'h0, 32'h0000_5A01);
    check("R2 arm", 32'(state_o), 1);
    rd(1'b1, 18'h0, 0, d, m);
    check("R11 ctl1 readback", d, 32'h0000_5A01);
  endtask

  task automatic t_armed();
    logic [31:0] d; logic m;
    wr(1'b1, 18'h4, 32'h0000_0A51);
    check("R4 ehv locked state", 32'(state_o), 1);
    check("R4 ehv locked hv_en", 32'(hv_en), 0);
    rd(1'b1, 18'h4, 0, d, m);
    check("R4 pulse width only", d, 32'h0000_0A50);
    check("R3 register write no buffer", 32'(buf_valid_o), 0);
    wr(1'b0, 18'h0_800C, 32'hF0F0_0F0F);
    check("R3 first write to fill", 32'(state_o), 2);
    check("R3 valid set", 32'(buf_valid_o), 32'h0008);
    check("R3 target latched", 32'(prog_addr_o), 32'h0_800C);
  endtask

  task automatic t_fill();
    logic [31:0] d; logic m;
    wr(1'b0, 18'h1_001C, 32'h0000_00FF);
    check("R5 second word valid", 32'(buf_valid_o), 32'h0088);
    check("R5 target unchanged", 32'(prog_addr_o), 32'h0_800C);
    check("R5 block updated", 32'(prog_blk_o), 2);
    wr(1'b0, 18'h0_000C, 32'h0000_0011);
    check("R5 block from latest", 32'(prog_blk_o), 0);
    rd(1'b0, 18'h0_000C, 32'h0000_0001, d, m);
    check("R8 margin flag", 32'(m), 1);
    check("R8 remaining after overwrite", d, 32'h0000_0010);
    check("R8 valid kept", 32'(buf_valid_o), 32'h0088);
    rd(1'b0, 18'h0_000C, 32'h0000_0010, d, m);
    check("R8 all done", d, 0);
    check("R8 valid dropped", 32'(buf_valid_o), 32'h0080);
    rd(1'b1, 18'h8, 0, d, m);
    check("R11 status fill", d, 32'h0080_0002);
  endtask

  task automatic t_hv();
    logic [31:0] d; logic m;
    wr(1'b1, 18'h4, 32'h0000_0001);
    check("R6 to hv", 32'(state_o), 3);
    check("R6 hv_en", 32'(hv_en), 1);
    wr(1'b0, 18'h0_0000, 32'hFFFF_FFFF);
    check("R9 array write ignored", 32'(buf_valid_o), 32'h0080);
    wr(1'b1, 18'h0, 32'h0000_0000);
    check("R9 ctl1 ignored state", 32'(state_o), 3);
    rd(1'b1, 18'h0, 0, d, m);
    check("R9 ctl1 unchanged", d, 32'h0000_5A01);
    wr(1'b1, 18'h4, 32'h0000_0000);
    check("R9 ehv clear to fill", 32'(state_o), 2);
    check("R9 hv_en low", 32'(hv_en), 0);
    wr(1'b1, 18'h4, 32'h0000_0001);
    check("R6 re-enter hv", 32'(state_o), 3);
    @(negedge clk);
    bus_sel_reg = 1'b1; bus_addr = 18'h4; bus_wdata = 32'h0000_0331;
    bus_wr = 1'b1; pulse_done = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pulse_done = 1'b0;
    check("R9 pulse_done wins state", 32'(state_o), 2);
    check("R9 pulse_done wins hv_en", 32'(hv_en), 0);
    rd(1'b1, 18'h4, 0, d, m);
    check("R9 width taken", d, 32'h0000_0330);
  endtask

  task automatic t_collide();
    logic [31:0] d; logic m;
    rd(1'b0, 18'h0_001C, 0, d, m);
    check("R8 pending word7", d, 32'h0000_00FF);
    @(negedge clk);
    bus_sel_reg = 1'b0; bus_addr = 18'h0_0014; bus_wdata = 32'h3;
    bus_wr = 1'b1; bus_rd = 1'b1; margin_pass = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; margin_pass = '0;
    check("R10 write done", 32'(buf_valid_o), 32'h00A0);
    check("R10 rdata held", bus_rdata, 32'h0000_00FF);
    rd(1'b0, 18'h0_001C, 0, d, m);
    check("R10 word7 not cleared", d, 32'h0000_00FF);
  endtask

  task automatic t_flush();
    logic [31:0] d; logic m;
    wr(1'b1, 18'h0, 32'h0000_0000);
    check("R7 fill to idle", 32'(state_o), 0);
    check("R7 buffer cleared", 32'(buf_valid_o), 0);
    array_rdata = 32'h1234_5678;
    rd(1'b0, 18'h0_001C, 32'hFFFF_FFFF, d, m);
    check("R8 idle normal read", d, 32'h1234_5678);
    check("R8 idle no margin", 32'(m), 0);
    wr(1'b1, 18'h0, 32'h0000_0001);
    wr(1'b0, 18'h0_0004, 32'h1);
    check("R3 refill", 32'(buf_valid_o), 32'h0002);
    wr(1'b1, 18'h0, 32'h0000_0000);
    check("R7 flush again", 32'(buf_valid_o), 0);
    wr(1'b1, 18'h0, 32'h0000_0001);
    wr(1'b1, 18'h0, 32'h0000_0000);
    check("R7 armed to idle", 32'(state_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_arm();
    t_armed();
    t_fill();
    t_hv();
    t_collide();
    t_flush();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule